// File: doc/BRIEF.md
# Target Bus Takeover Memory Controller

This block lets a local agent borrow the external bus of an 8-bit processor target and run byte-wide memory cycles on it. When it gets a command, it asks for the bus with an active-low request and waits for the target's active-low grant. Only after the grant does it drive the 19-bit address. It then runs a read or a write with active-low memory-enable, read and write strobes on an 8-bit data bus, which is split into data in, data out and a drive enable. At the end it hands the bus back in a fixed order.

A fill command writes one data byte to a run of consecutive addresses. Memory-enable stays low for the whole run, and the address steps by one after each write strobe. Some address lines have no external buffer. Each of those is tristated whenever the bus is not held. If the grant does not arrive within a bounded number of cycles, the block gives up and raises an error flag. It then releases the bus and reports completion.

Top module: `hbm_bus_master`

## Requirements
- R1: After reset, bus_req_no, mem_en_no, rd_no and wr_no are 1, data_oe_o is 0, busy_o, done_o and tmo_o are 0, and the bits of addr_oe_o at UNBUF_MASK positions (default 7 and 14..18) are 0.
- R2: After a start, bus_req_no goes low. No address bit at an UNBUF_MASK position is enabled, and no strobe is issued, until bus_ack_ni has been seen low.
- R3: A write enables the address, then lowers mem_en_no with data driven, then holds wr_no low for WR_LOW cycles, and then raises mem_en_no. done_o rises 2*D+WR_LOW+9 clock edges after the edge that samples start_i, where D is the grant delay in cycles (D of at least 1, symmetric on release).
- R4: A read holds rd_no low for RD_HOLD (at least 2) cycles, with mem_en_no low and data_oe_o 0. rdata_o holds the byte present on data_i in the last low cycle. done_o follows after 2*D+RD_HOLD+9 edges.
- R5: A write with fill_i=1 and len_i=N (N=0 treated as 1) writes wdata_i to addresses addr_i .. addr_i+N-1, which wrap modulo 2^19. mem_en_no stays low between strobes, and done_o comes 2*D+WR_LOW+9+(N-1)*(WR_LOW+2) edges after start. fill_i is ignored for reads.
- R6: Release happens in this order: data_oe_o goes to 0, then the unbuffered address enables go to 0, then bus_req_no goes high. done_o is raised only once bus_ack_ni has been seen high.
- R7: Address bits outside UNBUF_MASK are always enabled. Bits inside it are enabled only while the bus is granted.
- R8: start_i is ignored while busy_o is 1, including the cycle in which done_o is 1.
- R9: If bus_ack_ni stays high for TIMEOUT cycles in the grant wait, tmo_o is set, no strobe is issued, and done_o comes TIMEOUT+2 edges after start. A grant seen in the last wait cycle wins over the timeout. tmo_o clears on the next accepted start.
- R10: data_oe_o is never 1 while rd_no is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | command strobe, taken only when idle |
| write_i | input | 1 | 1 = write, 0 = read |
| fill_i | input | 1 | fill run (writes only) |
| len_i | input | LEN_W | fill byte count |
| addr_i | input | ADDR_W | start address |
| wdata_i | input | DATA_W | write byte |
| rdata_o | output | DATA_W | last read byte |
| busy_o | output | 1 | command in progress |
| done_o | output | 1 | one-cycle completion pulse |
| tmo_o | output | 1 | grant timeout flag |
| bus_req_no | output | 1 | bus request, active low |
| bus_ack_ni | input | 1 | bus grant, active low |
| addr_o | output | ADDR_W | target address |
| addr_oe_o | output | ADDR_W | per-bit address drive enable |
| data_o | output | DATA_W | data to target |
| data_i | input | DATA_W | data from target |
| data_oe_o | output | 1 | data drive enable |
| mem_en_no | output | 1 | memory enable, active low |
| rd_no | output | 1 | read strobe, active low |
| wr_no | output | 1 | write strobe, active low |

## Verification
The coincidence that matters is a grant arriving in the same cycle that the timeout counter reaches its limit. The bench provokes it by setting its model's grant delay to exactly TIMEOUT-1 cycles. It judges the result by the completion latency, by a real write landing in the target memory, and by tmo_o staying 0. A second same-cycle case is a start request presented in the done_o cycle. It is judged by busy_o being 0 a few cycles later, with no extra write seen by the target.

// File: rtl/hbm_pkg.sv
package hbm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ACQ, ST_ADR, ST_MEN, ST_STB, ST_RCV, ST_FADR,
    ST_MOFF, ST_RELD, ST_RELA, ST_RELR, ST_DONE
  } hbm_state_e;
endpackage

// File: rtl/hbm_grant_wait.sv
module hbm_grant_wait #(
  parameter int TIMEOUT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ack_ni,
  output logic granted_o,
  output logic expire_o
);
  localparam int TW = $clog2(TIMEOUT) + 1;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (ack_ni)         cnt_q <= cnt_q + 1'b1;
  end

  // grant checked ahead of expiry
  assign granted_o = run_i && !ack_ni;
  assign expire_o  = run_i && ack_ni && (cnt_q == TW'(TIMEOUT - 1));

  AST_TMO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < TW'(TIMEOUT))); // R9
endmodule

// File: rtl/hbm_pin_drive.sv
module hbm_pin_drive #(
  parameter int ADDR_W = 19,
  parameter logic [ADDR_W-1:0] UNBUF_MASK = 19'h7C080
) (
  input  logic              unbuf_en_i,
  output logic [ADDR_W-1:0] oe_o
);
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (UNBUF_MASK[i]) begin : g_unbuf
      assign oe_o[i] = unbuf_en_i;
    end else begin : g_buf
      assign oe_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/hbm_seq.sv
module hbm_seq
  import hbm_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 8,
  parameter int RD_HOLD = 2,
  parameter int WR_LOW  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic              fill_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_ni,
  input  logic              granted_i,
  input  logic              expire_i,
  output logic              acq_o,
  output logic              unbuf_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              data_oe_o,
  output logic              req_no,
  output logic              me_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic              busy_o,
  output logic              done_o,
  output logic              tmo_o
);
  localparam int SMAX = (RD_HOLD > WR_LOW) ? RD_HOLD : WR_LOW;
  localparam int SW   = $clog2(SMAX + 1);

  hbm_state_e        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              write_q, tmo_q;
  logic [LEN_W-1:0]  left_q;
  logic [SW-1:0]     stb_q, stb_last;

  assign stb_last = write_q ? SW'(WR_LOW - 1) : SW'(RD_HOLD - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      write_q <= 1'b0;
      tmo_q   <= 1'b0;
      left_q  <= '0;
      stb_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          write_q <= write_i;
          left_q  <= (write_i && fill_i && len_i != '0) ? len_i - 1'b1 : '0;
          tmo_q   <= 1'b0;
          st_q    <= ST_ACQ;
        end
        ST_ACQ: begin
          if (granted_i) st_q <= ST_ADR;
          else if (expire_i) begin
            tmo_q <= 1'b1;
            st_q  <= ST_RELR;
          end
        end
        ST_ADR: st_q <= ST_MEN;
        ST_MEN: begin
          stb_q <= '0;
          st_q  <= ST_STB;
        end
        ST_STB: begin
          if (stb_q == stb_last) begin
            if (!write_q) rdata_q <= data_i;
            st_q <= ST_RCV;
          end else begin
            stb_q <= stb_q + 1'b1;
          end
        end
        ST_RCV: begin
          if (left_q != '0) begin
            left_q <= left_q - 1'b1;
            addr_q <= addr_q + 1'b1;
            st_q   <= ST_FADR;
          end else begin
            st_q <= ST_MOFF;
          end
        end
        ST_FADR: begin
          stb_q <= '0;
          st_q  <= ST_STB;
        end
        ST_MOFF: st_q <= ST_RELD;
        ST_RELD: st_q <= ST_RELA;
        ST_RELA: st_q <= ST_RELR;
        ST_RELR: if (ack_ni) st_q <= ST_DONE;
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic me_act;
  assign me_act     = (st_q == ST_MEN) || (st_q == ST_STB) || (st_q == ST_RCV) || (st_q == ST_FADR);
  assign acq_o      = (st_q == ST_ACQ);
  assign unbuf_en_o = (st_q == ST_ADR) || me_act || (st_q == ST_MOFF) || (st_q == ST_RELD);
  assign req_no     = !(acq_o || unbuf_en_o || (st_q == ST_RELA));
  assign me_no      = !me_act;
  assign rd_no      = !((st_q == ST_STB) && !write_q);
  assign wr_no      = !((st_q == ST_STB) && write_q);
  assign data_oe_o  = write_q && (me_act || (st_q == ST_MOFF));
  assign addr_o     = addr_q;
  assign data_o     = wdata_q;
  assign rdata_o    = rdata_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_DONE);
  assign tmo_o      = tmo_q;

  AST_STROBE_UNDER_ME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> !me_no); // R3
  AST_ME_LEADS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_no) |-> $past(!me_no)); // R3
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !data_oe_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_NO_STROBE_ON_TMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> (rd_no && wr_no)); // R9
  if (RD_HOLD >= 2) begin : g_rd_chk
    AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rd_no) |=> !rd_no); // R4
  end
endmodule

// File: rtl/hbm_bus_master.sv
module hbm_bus_master #(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 8,
  parameter int RD_HOLD = 2,
  parameter int WR_LOW  = 1,
  parameter int TIMEOUT = 1024,
  parameter logic [ADDR_W-1:0] UNBUF_MASK = 19'h7C080
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic              fill_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              tmo_o,
  output logic              bus_req_no,
  input  logic              bus_ack_ni,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] addr_oe_o,
  output logic [DATA_W-1:0] data_o,
  input  logic [DATA_W-1:0] data_i,
  output logic              data_oe_o,
  output logic              mem_en_no,
  output logic              rd_no,
  output logic              wr_no
);
  logic acq, granted, expire, unbuf_en;

  hbm_grant_wait #(.TIMEOUT(TIMEOUT)) u_grant (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (acq),
    .ack_ni    (bus_ack_ni),
    .granted_o (granted),
    .expire_o  (expire)
  );

  hbm_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .RD_HOLD(RD_HOLD), .WR_LOW(WR_LOW)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .write_i    (write_i),
    .fill_i     (fill_i),
    .len_i      (len_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .data_i     (data_i),
    .ack_ni     (bus_ack_ni),
    .granted_i  (granted),
    .expire_i   (expire),
    .acq_o      (acq),
    .unbuf_en_o (unbuf_en),
    .addr_o     (addr_o),
    .data_o     (data_o),
    .rdata_o    (rdata_o),
    .data_oe_o  (data_oe_o),
    .req_no     (bus_req_no),
    .me_no      (mem_en_no),
    .rd_no      (rd_no),
    .wr_no      (wr_no),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .tmo_o      (tmo_o)
  );

  hbm_pin_drive #(.ADDR_W(ADDR_W), .UNBUF_MASK(UNBUF_MASK)) u_pins (
    .unbuf_en_i (unbuf_en),
    .oe_o       (addr_oe_o)
  );

  AST_UNBUF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((addr_oe_o & UNBUF_MASK) != '0) |-> !bus_req_no); // R7
  AST_REL_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_no) |-> (!data_oe_o && ((addr_oe_o & UNBUF_MASK) == '0))); // R6
  AST_BUF_ALWAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((addr_oe_o | UNBUF_MASK) == '1)); // R7
  AST_GRANT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_no && wr_no) |-> !bus_ack_ni); // R2
endmodule

// File: tb/sim_hbm_bus_master.sv
module sim_hbm_bus_master;
  localparam int PERIOD = 10;
  localparam int TMO    = 6;
  localparam int RDH    = 2;
  localparam int WRL    = 1;
  localparam logic [18:0] UNB = 19'h7C080;

  logic clk = 0, rst_n = 0;
  logic start = 0, wr = 0, fill = 0;
  logic [3:0]  len = 0;
  logic [18:0] addr = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata, data_o, data_i;
  logic busy, done, tmo, req_n, ack_n, data_oe, me_n, rd_n, wr_n;
  logic [18:0] addr_o, addr_oe;

  always #(PERIOD/2) clk = ~clk;

  hbm_bus_master #(.LEN_W(4), .RD_HOLD(RDH), .WR_LOW(WRL), .TIMEOUT(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(wr), .fill_i(fill),
    .len_i(len), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy),
    .done_o(done), .tmo_o(tmo), .bus_req_no(req_n), .bus_ack_ni(ack_n),
    .addr_o(addr_o), .addr_oe_o(addr_oe), .data_o(data_o), .data_i(data_i),
    .data_oe_o(data_oe), .mem_en_no(me_n), .rd_no(rd_n), .wr_no(wr_n)
  );

  int n_vec = 0, n_bad = 0;
  int dly = 1;
  bit never = 0;
  logic [7:0] sr = '1;
  always @(posedge clk) sr <= {sr[6:0], req_n | never};
  assign ack_n = never ? 1'b1 : sr[dly-1];

  // target memory model
  logic [7:0]  mem [0:255];
  int          wcnt = 0;
  logic [18:0] last_wa = 0;
  bit          pend = 0;
  logic [18:0] pa;
  logic [7:0]  pd;
  assign data_i = (!rd_n && !me_n) ? mem[addr_o[7:0]] : 8'h00;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (!wr_n) begin
      pend = 1; pa = addr_o; pd = data_o;
      chk("R3 strobe under me", {31'b0, me_n}, 0);
      chk("R3 data driven", {31'b0, data_oe}, 1);
    end else if (pend) begin
      pend = 0; mem[pa[7:0]] = pd; wcnt++; last_wa = pa;
    end
    if ((addr_oe & UNB) != 0) chk("R2 unbuf only when granted", {31'b0, ack_n}, 0);
    chk("R7 buffered bits driven", {13'b0, addr_oe | UNB}, {13'b0, 19'h7FFFF});
    if (!rd_n) chk("R10 no drive on read", {31'b0, data_oe}, 0);
    if (req_n) chk("R6 released lines", {31'b0, data_oe || ((addr_oe & UNB) != 0)}, 0);
  end

  // run one command; returns latency in edges
  task automatic op(input bit w, input bit f, input logic [3:0] n, input logic [18:0] a,
                    input logic [7:0] d, input bit inject, output int lat);
    @(negedge clk);
    wr = w; fill = f; len = n; addr = a; wdata = d; start = 1;
    @(negedge clk);
    start = 0; lat = 1;
    while (!done && lat < 400) begin
      @(negedge clk); lat++;
      if (inject && lat == 3) begin
        start = 1; wr = 1; fill = 0; addr = a ^ 19'h00055; wdata = ~d;
      end else start = 0;
    end
    // start in the done cycle must be dropped (R8)
    start = 1; wr = 1; fill = 0; addr = a ^ 19'h000AA; wdata = ~d;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    chk("R8 start in done cycle ignored", {31'b0, busy}, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int lat, w0;
    logic [18:0] a;
    logic [7:0] d, lo;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    #(PERIOD * 3);
    @(negedge clk);
    chk("R1 req", {31'b0, req_n}, 1);
    chk("R1 strobes", {29'b0, me_n, rd_n, wr_n}, 3'b111);
    chk("R1 flags", {28'b0, data_oe, busy, done, tmo}, 0);
    chk("R1 unbuf oe", {13'b0, addr_oe & UNB}, 0);
    rst_n = 1;

    for (int dd = 1; dd <= 3; dd++) begin
      dly = dd;
      repeat (10) @(negedge clk);
      for (int k = 0; k < 8; k++) begin
        lo = 8'(k * 29 + dd * 7);
        a  = (19'(k) * 19'h09249 & 19'h7FF00) | 19'(lo);
        d  = 8'(k * 37 + dd * 11 + 1);
        w0 = wcnt;
        op(1, 0, 0, a, d, k == 2, lat);
        chk("R3 write latency", lat, 2 * dd + WRL + 9);
        chk("R3 write data", {24'b0, mem[lo]}, {24'b0, d});
        chk("R8 one write only", wcnt - w0, 1);
        chk("R3 write addr", {13'b0, last_wa}, {13'b0, a});
      end
      for (int k = 0; k < 8; k++) begin
        lo = 8'(k * 29 + dd * 7);
        a  = (19'(k) * 19'h09249 & 19'h7FF00) | 19'(lo);
        d  = 8'(k * 37 + dd * 11 + 1);
        w0 = wcnt;
        op(0, 0, 0, a, 8'h00, k == 5, lat);
        chk("R4 read latency", lat, 2 * dd + RDH + 9);
        chk("R4 read data", {24'b0, rdata}, {24'b0, d});
        chk("R8 read no write", wcnt - w0, 0);
      end
    end

    dly = 2;
    for (int c = 0; c < 5; c++) begin
      int nb, nl;
      nl = (c == 4) ? 0 : ((c == 3) ? 5 : c + 1);
      nb = (nl == 0) ? 1 : nl;
      a  = (c == 3) ? 19'h7FFFE : 19'h12340 + 19'(c * 16);
      d  = 8'hA0 + 8'(c);
      w0 = wcnt;
      op(1, 1, 4'(nl), a, d, 0, lat);
      chk("R5 fill latency", lat, 2 * 2 + WRL + 9 + (nb - 1) * (WRL + 2));
      chk("R5 fill count", wcnt - w0, nb);
      chk("R5 fill last addr", {13'b0, last_wa}, {13'b0, a + 19'(nb - 1)});
      for (int j = 0; j < nb; j++)
        chk("R5 fill data", {24'b0, mem[8'(a) + 8'(j)]}, {24'b0, d});
    end
    w0 = wcnt;
    op(0, 1, 4'd4, 19'h12340, 8'h00, 0, lat);
    chk("R5 fill ignored on read latency", lat, 2 * 2 + RDH + 9);
    chk("R5 fill ignored on read data", {24'b0, rdata}, 32'hA0);
    chk("R5 read no write", wcnt - w0, 0);

    never = 1;
    repeat (4) @(negedge clk);
    w0 = wcnt;
    op(1, 0, 0, 19'h00033, 8'h5A, 0, lat);
    chk("R9 timeout latency", lat, TMO + 2);
    chk("R9 timeout flag", {31'b0, tmo}, 1);
    chk("R9 no write on timeout", wcnt - w0, 0);
    never = 0;
    dly = TMO - 1;
    repeat (10) @(negedge clk);
    w0 = wcnt;
    op(1, 0, 0, 19'h00044, 8'hC3, 0, lat);
    chk("R9 grant on last wait cycle latency", lat, 2 * (TMO - 1) + WRL + 9);
    chk("R9 flag cleared", {31'b0, tmo}, 0);
    chk("R9 write landed", {24'b0, mem[8'h44]}, 32'hC3);
    chk("R9 one write", wcnt - w0, 1);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule